// File: doc/BRIEF.md
# CAN Mailbox Event Flag Bank

This block keeps the per-mailbox event flags of a 32-mailbox CAN controller. Two flag groups are held: one marks mailboxes that have stored a data frame and wait for software (receive-pending), the other marks mailboxes whose transmit cancellation has finished (abort-acknowledge). Both are set by single-cycle event pulses from the message-handling logic. Software reads them over a 16-bit register bus and clears them by writing ones.

A receive-pending bit is set only when the stored frame is a data frame and that mailbox is configured to receive data frames. The receive-pending group also drives a data-frame-received summary flag, which only unmasked mailboxes can raise. The summary drives the interrupt line only while its global mask is clear. Mailbox 0 is receive-only, so its abort-acknowledge bit is fixed at zero.

Top module: `can_mbx_flags`

## Requirements
- R1: After reset, both flag groups and the summary flag read 0, both per-mailbox mask registers read 0xFFFF, the global mask register reads 0x0001 and `irqRx` is low.
- R2: Register addresses are 0 pending low, 1 pending high, 2 abort low, 3 abort high, 4 mask low, 5 mask high, 6 summary (bit 0), 7 global mask (bit 0). Bit k of a low register is mailbox k and bit k of a high register is mailbox k+16. Unused bits read 0. `busRdata` follows `busAddr` combinationally.
- R3: A `dataStored` pulse on mailbox m sets its pending bit at the next clock edge, if `rxDataCfg[m]` is 1 and `remoteStored[m]` is 0 in that cycle.
- R4: A `remoteStored` pulse alone, or a `dataStored` pulse on a mailbox whose `rxDataCfg` bit is 0, leaves the pending bit unchanged.
- R5: A write with `busSel` and `busWrite` high to a pending or abort register clears each flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R6: When a set event and a write-one clear hit the same flag in the same cycle, the flag ends up set.
- R7: A `cancelDone` pulse on mailbox m (m > 0) sets its abort bit at the next edge. The abort bit of mailbox 0 always reads 0, whatever the pulses or writes.
- R8: The summary flag becomes 1 at the edge after any pending bit whose mailbox mask bit is 0 is set. Pending bits whose mailboxes are masked never raise it.
- R9: Writing 1 to bit 0 at address 6 clears the summary flag. It sets again one edge later if an unmasked pending bit is still set.
- R10: `irqRx` is high exactly when the summary flag is 1 and the global mask bit is 0.
- R11: Mask registers take the written value at the next edge. Reads change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Register access strobe |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 3 | Register address |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data for `busAddr` |
| dataStored | input | 32 | Per-mailbox pulse: data frame stored |
| remoteStored | input | 32 | Per-mailbox pulse: remote frame stored |
| cancelDone | input | 32 | Per-mailbox pulse: transmit cancellation finished |
| rxDataCfg | input | 32 | Per-mailbox: 1 = configured to receive data frames |
| irqRx | output | 1 | Data-frame-received interrupt |

## Verification
The bench builds the block with the default half-register width of 16, which gives 32 mailboxes. At this width both register halves exist, so the crossing from mailbox 15 to mailbox 16 can be tested, as can the fixed-zero abort bit of mailbox 0. The same width lets the bench's behavioural model map mailboxes onto the same register bits that software sees. The bench then drives mixed data, remote and unconfigured events, clears that coincide with sets, and summary clears while unmasked pending bits remain.

// File: rtl/can_mbx_flags_pkg.sv
package can_mbx_flags_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_PEND_LO = 3'd0,
    RA_PEND_HI = 3'd1,
    RA_ABT_LO  = 3'd2,
    RA_ABT_HI  = 3'd3,
    RA_MSK_LO  = 3'd4,
    RA_MSK_HI  = 3'd5,
    RA_SUM     = 3'd6,
    RA_GLB     = 3'd7
  } reg_addr_e;

  // Write strobes passed from the bus decoder to the flag datapath
  typedef struct packed {
    logic clrPendLo;
    logic clrPendHi;
    logic clrAbtLo;
    logic clrAbtHi;
    logic wrMskLo;
    logic wrMskHi;
    logic clrSum;
    logic wrGlb;
  } strobe_t;
endpackage

// File: rtl/mbx_flags_ctrl.sv
module mbx_flags_ctrl
  import can_mbx_flags_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic                   busSel,
  input  logic                   busWrite,
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic [2*REG_W-1:0]     pendVec,
  input  logic [2*REG_W-1:0]     abtVec,
  input  logic [2*REG_W-1:0]     mskVec,
  input  logic                   sumFlag,
  input  logic                   glbMask,
  output strobe_t                strobes,
  output logic [REG_W-1:0]       busRdata
);
  logic      wrEn;
  reg_addr_e addrE;

  assign wrEn  = busSel & busWrite;
  assign addrE = reg_addr_e'(busAddr);

  always_comb begin
    strobes = '0;
    if (wrEn) begin
      unique case (addrE)
        RA_PEND_LO: strobes.clrPendLo = 1'b1;
        RA_PEND_HI: strobes.clrPendHi = 1'b1;
        RA_ABT_LO:  strobes.clrAbtLo  = 1'b1;
        RA_ABT_HI:  strobes.clrAbtHi  = 1'b1;
        RA_MSK_LO:  strobes.wrMskLo   = 1'b1;
        RA_MSK_HI:  strobes.wrMskHi   = 1'b1;
        RA_SUM:     strobes.clrSum    = 1'b1;
        RA_GLB:     strobes.wrGlb     = 1'b1;
        default:    strobes = '0;
      endcase
    end
  end

  // Side-effect-free read path
  always_comb begin
    unique case (addrE)
      RA_PEND_LO: busRdata = pendVec[REG_W-1:0];
      RA_PEND_HI: busRdata = pendVec[2*REG_W-1:REG_W];
      RA_ABT_LO:  busRdata = abtVec[REG_W-1:0];
      RA_ABT_HI:  busRdata = abtVec[2*REG_W-1:REG_W];
      RA_MSK_LO:  busRdata = mskVec[REG_W-1:0];
      RA_MSK_HI:  busRdata = mskVec[2*REG_W-1:REG_W];
      RA_SUM:     busRdata = {{(REG_W-1){1'b0}}, sumFlag};
      RA_GLB:     busRdata = {{(REG_W-1){1'b0}}, glbMask};
      default:    busRdata = '0;
    endcase
  end
endmodule

// File: rtl/mbx_flags_dp.sv
module mbx_flags_dp
  import can_mbx_flags_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                strobes,
  input  logic [REG_W-1:0]       busWdata,
  input  logic [2*REG_W-1:0]     dataStored,
  input  logic [2*REG_W-1:0]     remoteStored,
  input  logic [2*REG_W-1:0]     cancelDone,
  input  logic [2*REG_W-1:0]     rxDataCfg,
  output logic [2*REG_W-1:0]     pendVec,
  output logic [2*REG_W-1:0]     abtVec,
  output logic [2*REG_W-1:0]     mskVec,
  output logic                   sumFlag,
  output logic                   glbMask,
  output logic                   irqRx
);
  localparam int NMBX = 2 * REG_W;
  localparam logic [NMBX-1:0] ABT_KEEP = ~(NMBX'(1));

  logic [NMBX-1:0] pendClr, abtClr, mskNext;
  logic [NMBX-1:0] pendSet, pendNext, abtNext;
  logic            anyUnmasked, sumNext;

  // Per-half clear vectors and mask write data
  for (genvar h = 0; h < 2; h++) begin : g_half
    localparam int LO = h * REG_W;
    logic selPend, selAbt, selMsk;
    assign selPend = (h == 0) ? strobes.clrPendLo : strobes.clrPendHi;
    assign selAbt  = (h == 0) ? strobes.clrAbtLo  : strobes.clrAbtHi;
    assign selMsk  = (h == 0) ? strobes.wrMskLo   : strobes.wrMskHi;
    assign pendClr[LO +: REG_W] = selPend ? busWdata : '0;
    assign abtClr[LO +: REG_W]  = selAbt  ? busWdata : '0;
    assign mskNext[LO +: REG_W] = selMsk  ? busWdata : mskVec[LO +: REG_W];
  end

  // Only a data frame in a data-receive mailbox qualifies
  assign pendSet  = dataStored & rxDataCfg & ~remoteStored;
  // Hardware set takes priority over software clear
  assign pendNext = (pendVec & ~pendClr) | pendSet;
  // Mailbox 0 abort flag pinned low
  assign abtNext  = ((abtVec & ~abtClr) | cancelDone) & ABT_KEEP;

  assign anyUnmasked = |(pendVec & ~mskVec);
  assign sumNext     = (strobes.clrSum && busWdata[0]) ? 1'b0 : (sumFlag | anyUnmasked);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendVec <= '0;
      abtVec  <= '0;
      mskVec  <= '1;
      sumFlag <= 1'b0;
      glbMask <= 1'b1;
    end else begin
      pendVec <= pendNext;
      abtVec  <= abtNext;
      mskVec  <= mskNext;
      sumFlag <= sumNext;
      if (strobes.wrGlb) glbMask <= busWdata[0];
    end
  end

  assign irqRx = sumFlag & ~glbMask;
endmodule

// File: rtl/can_mbx_flags.sv
module can_mbx_flags
  import can_mbx_flags_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   busSel,
  input  logic                   busWrite,
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic [REG_W-1:0]       busWdata,
  output logic [REG_W-1:0]       busRdata,
  input  logic [2*REG_W-1:0]     dataStored,
  input  logic [2*REG_W-1:0]     remoteStored,
  input  logic [2*REG_W-1:0]     cancelDone,
  input  logic [2*REG_W-1:0]     rxDataCfg,
  output logic                   irqRx
);
  strobe_t            strobes;
  logic [2*REG_W-1:0] pendVec, abtVec, mskVec;
  logic               sumFlag, glbMask;

  mbx_flags_ctrl #(.REG_W(REG_W)) u_ctrl (
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .pendVec  (pendVec),
    .abtVec   (abtVec),
    .mskVec   (mskVec),
    .sumFlag  (sumFlag),
    .glbMask  (glbMask),
    .strobes  (strobes),
    .busRdata (busRdata)
  );

  mbx_flags_dp #(.REG_W(REG_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .busWdata     (busWdata),
    .dataStored   (dataStored),
    .remoteStored (remoteStored),
    .cancelDone   (cancelDone),
    .rxDataCfg    (rxDataCfg),
    .pendVec      (pendVec),
    .abtVec       (abtVec),
    .mskVec       (mskVec),
    .sumFlag      (sumFlag),
    .glbMask      (glbMask),
    .irqRx        (irqRx)
  );
endmodule

// File: rtl/can_mbx_flags_chk.sv
module can_mbx_flags_chk
  import can_mbx_flags_pkg::*;
#(
  parameter int REG_W = 16
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 busSel,
  input logic                 busWrite,
  input logic [ADDR_W-1:0]    busAddr,
  input logic [REG_W-1:0]     busWdata,
  input logic [2*REG_W-1:0]   dataStored,
  input logic [2*REG_W-1:0]   remoteStored,
  input logic [2*REG_W-1:0]   rxDataCfg,
  input logic [2*REG_W-1:0]   pendVec,
  input logic [2*REG_W-1:0]   abtVec,
  input logic [2*REG_W-1:0]   mskVec,
  input logic                 sumFlag
);
  localparam int NMBX = 2 * REG_W;

  logic [NMBX-1:0] qual, swClr;
  logic            wrEn;

  assign wrEn  = busSel && busWrite;
  assign qual  = dataStored & rxDataCfg & ~remoteStored;
  assign swClr = {(wrEn && busAddr == 3'd1) ? busWdata : {REG_W{1'b0}},
                  (wrEn && busAddr == 3'd0) ? busWdata : {REG_W{1'b0}}};

  p_pend_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((pendVec & $past(qual)) == $past(qual)));

  p_pend_cause_r4: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((pendVec & ~$past(pendVec) & ~$past(qual)) == '0));

  p_clear_needs_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((~pendVec & $past(pendVec) & ~$past(swClr)) == '0));

  p_set_beats_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((pendVec & $past(swClr & qual)) == $past(swClr & qual)));

  p_abt_bit0_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    abtVec[0] == 1'b0);

  p_sum_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sumFlag) |-> $past(|(pendVec & ~mskVec)));
endmodule

bind can_mbx_flags can_mbx_flags_chk #(.REG_W(REG_W)) u_chk (.*);

// File: tb/can_mbx_flags_test.sv
`timescale 1ns/1ps
module can_mbx_flags_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWrite = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic [31:0] dataStored = '0, remoteStored = '0, cancelDone = '0, rxDataCfg = '0;
  logic        irqRx;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // Behavioural reference state, one bit per mailbox
  bit mPend[32];
  bit mAbt[32];
  bit mMsk[32];
  bit mSum;
  bit mGlb;

  always #4 clk = ~clk;

  can_mbx_flags uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .dataStored(dataStored), .remoteStored(remoteStored),
    .cancelDone(cancelDone), .rxDataCfg(rxDataCfg), .irqRx(irqRx)
  );

  always @(posedge clk) begin
    bit anyU;
    bit wr;
    int half;
    int b;
    if (!rstN) begin
      for (int i = 0; i < 32; i++) begin
        mPend[i] = 0; mAbt[i] = 0; mMsk[i] = 1;
      end
      mSum = 0;
      mGlb = 1;
    end else begin
      anyU = 0;
      for (int i = 0; i < 32; i++) if (mPend[i] && !mMsk[i]) anyU = 1;
      wr = busSel && busWrite;
      for (int i = 0; i < 32; i++) begin
        half = i / 16;
        b = i % 16;
        if (wr && busWdata[b] && busAddr == 3'(half)) mPend[i] = 0;
        if (dataStored[i] && rxDataCfg[i] && !remoteStored[i]) mPend[i] = 1;
        if (wr && busWdata[b] && busAddr == 3'(2 + half)) mAbt[i] = 0;
        if (cancelDone[i]) mAbt[i] = 1;
        if (i == 0) mAbt[i] = 0;
        if (wr && busAddr == 3'(4 + half)) mMsk[i] = busWdata[b];
      end
      if (wr && busAddr == 3'd6 && busWdata[0]) mSum = 0;
      else if (anyU) mSum = 1;
      if (wr && busAddr == 3'd7) mGlb = busWdata[0];
    end
  end

  function automatic logic [15:0] expRead(input logic [2:0] a);
    logic [15:0] v = '0;
    for (int k = 0; k < 16; k++) begin
      case (a)
        3'd0: v[k] = mPend[k];
        3'd1: v[k] = mPend[k+16];
        3'd2: v[k] = mAbt[k];
        3'd3: v[k] = mAbt[k+16];
        3'd4: v[k] = mMsk[k];
        3'd5: v[k] = mMsk[k+16];
        default: v[k] = 1'b0;
      endcase
    end
    if (a == 3'd6) v[0] = mSum;
    if (a == 3'd7) v[0] = mGlb;
    return v;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // R10: interrupt compared with the model on every cycle
  always @(negedge clk) begin
    if (rstN) check("R10 irq", {15'd0, irqRx}, {15'd0, (mSum && !mGlb)});
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic readReg(input string tag, input logic [2:0] a);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    #1;
    check(tag, busRdata, expRead(a));
    busSel = 1'b0;
  endtask

  task automatic readAll(input string tag);
    for (int a = 0; a < 8; a++) readReg(tag, 3'(a));
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busSel = 1'b0; busWrite = 1'b0; busWdata = '0;
  endtask

  task automatic pulse(input logic [31:0] ds, input logic [31:0] rs, input logic [31:0] cd);
    @(negedge clk);
    dataStored = ds; remoteStored = rs; cancelDone = cd;
    @(posedge clk); #1;
    dataStored = '0; remoteStored = '0; cancelDone = '0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    readAll("R1 reset");
    @(negedge clk); rstN = 1'b1;
    readAll("R1 after release");
    check("R1 irq low", {15'd0, irqRx}, 16'h0000);

    rxDataCfg = 32'h0F0F_F0F0;
    // configured mbx 4 sets; unconfigured 0 and 20 do not
    pulse(32'h0010_0011, '0, '0);
    readReg("R3 pend lo", 3'd0);
    check("R3 pend lo literal", busRdata, 16'h0010);
    readReg("R4 pend hi", 3'd1);
    // remote alone on 5, data+remote on 6
    pulse(32'h0000_0040, 32'h0000_0060, '0);
    readReg("R4 remote", 3'd0);
    // mailbox 17 lands in high half bit 1
    pulse(32'h0002_0000, '0, '0);
    readReg("R2 hi half", 3'd1);
    check("R2 hi literal", busRdata, 16'h0002);

    writeReg(3'd0, 16'h0000);
    readReg("R5 zero write", 3'd0);
    writeReg(3'd0, 16'h0010);
    readReg("R5 one clears", 3'd0);
    check("R5 literal", busRdata, 16'h0000);

    // set and clear on mbx 4 in the same cycle
    @(negedge clk);
    dataStored = 32'h0000_0010;
    busSel = 1'b1; busWrite = 1'b1; busAddr = 3'd0; busWdata = 16'h0010;
    @(posedge clk); #1;
    dataStored = '0; busSel = 1'b0; busWrite = 1'b0; busWdata = '0;
    readReg("R6 set wins", 3'd0);
    check("R6 literal", busRdata, 16'h0010);

    pulse('0, '0, 32'hFFFF_FFFF);
    readReg("R7 abt lo", 3'd2);
    check("R7 bit0 zero", busRdata, 16'hFFFE);
    readReg("R7 abt hi", 3'd3);
    writeReg(3'd2, 16'h0001);
    readReg("R7 bit0 write", 3'd2);
    writeReg(3'd2, 16'hFFFF);
    writeReg(3'd3, 16'h00FF);
    readAll("R5 abort clears");

    // all masked: summary stays low
    repeat (2) @(posedge clk);
    readReg("R8 masked", 3'd6);
    writeReg(3'd4, 16'hFFEF);
    readReg("R11 mask", 3'd4);
    @(posedge clk);
    readReg("R8 summary up", 3'd6);
    check("R8 literal", busRdata, 16'h0001);
    check("R10 global masked", {15'd0, irqRx}, 16'h0000);
    writeReg(3'd7, 16'h0000);
    readReg("R11 glb", 3'd7);
    check("R10 irq up", {15'd0, irqRx}, 16'h0001);

    writeReg(3'd6, 16'h0001);
    readReg("R9 cleared", 3'd6);
    check("R9 literal low", busRdata, 16'h0000);
    @(posedge clk);
    readReg("R9 re-set", 3'd6);
    check("R9 literal high", busRdata, 16'h0001);

    writeReg(3'd0, 16'hFFFF);
    writeReg(3'd1, 16'hFFFF);
    writeReg(3'd6, 16'h0001);
    repeat (3) @(posedge clk);
    readAll("R9 stays clear");
    check("R10 irq down", {15'd0, irqRx}, 16'h0000);

    // mailbox 16 unmasked in high half
    writeReg(3'd5, 16'hFFFE);
    pulse(32'h0001_0000, '0, '0);
    repeat (2) @(posedge clk);
    readAll("R11 hi mask");
    readAll("R11 read no side effect");

    repeat (2) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule